// File: doc/BRIEF.md
# Per-Digit Seven-Segment Character Decoder

This block converts the stored byte of the digit that is being scanned into the eight segment lines of a common display. A decode mask holds one bit per digit. When a digit's bit is set, the low nibble of its byte is looked up in a character font. When the bit is clear, the byte goes straight to the segment lines unchanged. A single font-select input chooses between two fonts. The hexadecimal font shows 0-9 and A-F. The numeric font shows 0-9 followed by a dash, E, H, L, P and a blank.

In both modes, the top data bit drives the decimal point directly. In decode mode, data bits 6:4 are ignored. The segment byte is registered, so it follows the digit index, the data, the mask and the font select with one clock of latency. The scan controller can therefore present each new digit one cycle before that digit's common line is driven.

Top module: `digit_seg_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `seg_o` is 8'h00 (all segments and DP off).
- R2: When bit `digit_idx` of `decode_mask` is 0, `seg_o` equals `digit_byte` one clock later, whatever `hex_font` is.
- R3: The segment output order is `seg_o[7]`=DP, `seg_o[6]`=A, `seg_o[5]`=B, `seg_o[4]`=C, `seg_o[3]`=D, `seg_o[2]`=E, `seg_o[1]`=F, `seg_o[0]`=G. In bypass mode, each data bit lands on the output bit with the same index.
- R4: In decode mode, changing `digit_byte[6:4]` has no effect on `seg_o`.
- R5: `seg_o[7]` equals `digit_byte[7]` one clock later in both decode and bypass mode.
- R6: With `hex_font`=0 in decode mode, nibbles 0-9 give the digits 0-9 using the usual segments. For example, 0 lights A-F, 1 lights B and C, and 8 lights A-G.
- R7: With `hex_font`=0 in decode mode, nibbles 0xA-0xF give dash (G), E (ADEFG), H (BCEFG), L (DEF), P (ABEFG) and blank, in that order.
- R8: With `hex_font`=1 in decode mode, nibbles 0-9 match R6, and 0xA-0xF give A (ABCEFG), b (CDEFG), C (ADEF), d (BCDEG), E (ADEFG) and F (AEFG).
- R9: A change on any input (`digit_idx`, `digit_byte`, `decode_mask`, `hex_font`) appears on `seg_o` exactly one rising clock edge later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_byte | input | 8 | Stored byte of the digit being scanned |
| digit_idx | input | 3 | Index of the digit being scanned |
| decode_mask | input | 8 | Per-digit decode enable, bit n for digit n |
| hex_font | input | 1 | 1 selects the hexadecimal font, 0 the numeric font |
| seg_o | output | 8 | Registered segment lines, DP,A,B,C,D,E,F,G from bit 7 down |

## Verification
The bench targets the codes where the two fonts differ, 0xA-0xF. A design that swapped the fonts, or that shifted the numeric font's symbol order, would show letters where a dash or a blank belongs. It also sets bits 6:4 under decode and toggles the decimal point with the mask both set and clear. This exposes a decoder that indexes with more than the nibble, or that gates DP with the font. Walking-one bytes in bypass catch a reversed or rotated segment order. A per-digit sweep with a single mask bit set catches selecting the mask bit with the wrong index. A sample taken between the input change and the next edge catches an output that is combinational or delayed by a second register.

// File: rtl/digit_seg_pkg.sv
package digit_seg_pkg;

   // Seven segment bits, A in bit 6 down to G in bit 0
   typedef logic [6:0] seg7_t;

   localparam seg7_t SEG_BLANK = 7'b000_0000;

   // Digits 0..9, shared by both fonts
   function automatic seg7_t numeral_glyph(input logic [3:0] nib);
      seg7_t g;
      case (nib)
         4'd0:    g = 7'b111_1110;
         4'd1:    g = 7'b011_0000;
         4'd2:    g = 7'b110_1101;
         4'd3:    g = 7'b111_1001;
         4'd4:    g = 7'b011_0011;
         4'd5:    g = 7'b101_1011;
         4'd6:    g = 7'b101_1111;
         4'd7:    g = 7'b111_0000;
         4'd8:    g = 7'b111_1111;
         4'd9:    g = 7'b111_1011;
         default: g = SEG_BLANK;
      endcase
      return g;
   endfunction

   // Numeric font: 0-9, then dash, E, H, L, P, blank
   function automatic seg7_t numeric_font(input logic [3:0] nib);
      seg7_t g;
      case (nib)
         4'hA:    g = 7'b000_0001;
         4'hB:    g = 7'b100_1111;
         4'hC:    g = 7'b011_0111;
         4'hD:    g = 7'b000_1110;
         4'hE:    g = 7'b110_0111;
         4'hF:    g = SEG_BLANK;
         default: g = numeral_glyph(nib);
      endcase
      return g;
   endfunction

   // Hexadecimal font: 0-9, A b C d E F
   function automatic seg7_t hex_glyph(input logic [3:0] nib);
      seg7_t g;
      case (nib)
         4'hA:    g = 7'b111_0111;
         4'hB:    g = 7'b001_1111;
         4'hC:    g = 7'b100_1110;
         4'hD:    g = 7'b011_1101;
         4'hE:    g = 7'b100_1111;
         4'hF:    g = 7'b100_0111;
         default: g = numeral_glyph(nib);
      endcase
      return g;
   endfunction

endpackage

// File: rtl/dsd_mask_pick.sv
module dsd_mask_pick #(
   parameter int NUM_DIGITS = 8,
   parameter int IDX_W      = 3
) (
   input  logic [NUM_DIGITS-1:0] mask,
   input  logic [IDX_W-1:0]      idx,
   output logic                  decode_en
);
   logic [NUM_DIGITS-1:0] hit;

   generate
      for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_lane
         assign hit[d] = mask[d] && (idx == IDX_W'(d));
      end
   endgenerate

   // An index past the last digit hits nothing and so bypasses
   assign decode_en = |hit;
endmodule

// File: rtl/dsd_font.sv
module dsd_font #(
   parameter bit HEX_SET = 1'b0
) (
   input  logic [3:0]               nib,
   output digit_seg_pkg::seg7_t     glyph
);
   import digit_seg_pkg::*;

   generate
      if (HEX_SET) begin : g_hex
         always_comb glyph = hex_glyph(nib);
      end else begin : g_num
         always_comb glyph = numeric_font(nib);
      end
   endgenerate
endmodule

// File: rtl/digit_seg_decoder.sv
module digit_seg_decoder #(
   parameter int NUM_DIGITS = 8,
   parameter int DATA_W     = 8
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic [DATA_W-1:0]                                digit_byte,
   input  logic [((NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1)-1:0] digit_idx,
   input  logic [NUM_DIGITS-1:0]                            decode_mask,
   input  logic                                             hex_font,
   output logic [DATA_W-1:0]                                seg_o
);
   import digit_seg_pkg::*;

   localparam int IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
   localparam int DP_BIT = DATA_W - 1;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("digit_seg_decoder: DATA_W must be 8 (seven segments plus point)");
      end
      if (NUM_DIGITS < 1 || NUM_DIGITS > 16) begin : g_bad_digits
         $error("digit_seg_decoder: NUM_DIGITS must lie in 1..16");
      end
   endgenerate

   logic  decode_en;
   seg7_t glyph_num;
   seg7_t glyph_hex;
   seg7_t glyph;
   logic [DATA_W-1:0] seg_next;

   dsd_mask_pick #(
      .NUM_DIGITS(NUM_DIGITS),
      .IDX_W     (IDX_W)
   ) u_pick (
      .mask     (decode_mask),
      .idx      (digit_idx),
      .decode_en(decode_en)
   );

   dsd_font #(.HEX_SET(1'b0)) u_font_num (
      .nib  (digit_byte[3:0]),
      .glyph(glyph_num)
   );

   dsd_font #(.HEX_SET(1'b1)) u_font_hex (
      .nib  (digit_byte[3:0]),
      .glyph(glyph_hex)
   );

   always_comb begin
      glyph    = hex_font ? glyph_hex : glyph_num;
      seg_next = decode_en ? {digit_byte[DP_BIT], glyph} : digit_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_o <= '0;
      else        seg_o <= seg_next;
   end
endmodule

// File: rtl/dsd_chk.sv
module dsd_chk #(
   parameter int NUM_DIGITS = 8,
   parameter int IDX_W      = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [7:0]            digit_byte,
   input logic [IDX_W-1:0]      digit_idx,
   input logic [NUM_DIGITS-1:0] decode_mask,
   input logic                  hex_font,
   input logic [7:0]            seg_o
);
   // R1
   reset_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> seg_o == 8'h00);

   // R2
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !decode_mask[digit_idx] |=> seg_o == $past(digit_byte));

   // R5
   point_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> seg_o[7] == $past(digit_byte[7]));

   // R4
   upper_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_mask[digit_idx] && $stable(digit_idx) && $stable(decode_mask)
       && $stable(hex_font) && $stable(digit_byte[3:0]) && $stable(digit_byte[7])
       && $past(rst_n))
      |=> $stable(seg_o));

   // R7
   numeric_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_mask[digit_idx] && !hex_font && digit_byte[3:0] == 4'hF)
      |=> seg_o[6:0] == 7'h00);

   // R8
   hex_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_mask[digit_idx] && digit_byte[3:0] == 4'h8)
      |=> seg_o[6:0] == 7'h7F);
endmodule

bind digit_seg_decoder dsd_chk #(
   .NUM_DIGITS(NUM_DIGITS),
   .IDX_W     (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .digit_byte (digit_byte),
   .digit_idx  (digit_idx),
   .decode_mask(decode_mask),
   .hex_font   (hex_font),
   .seg_o      (seg_o)
);

// File: tb/digit_seg_decoder_test.sv
module digit_seg_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] digit_byte = '0;
   logic [2:0] digit_idx = '0;
   logic [7:0] decode_mask = '0;
   logic       hex_font = 1'b0;
   logic [7:0] seg_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   digit_seg_decoder uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .digit_byte (digit_byte),
      .digit_idx  (digit_idx),
      .decode_mask(decode_mask),
      .hex_font   (hex_font),
      .seg_o      (seg_o)
   );

   // Segment letters to bit pattern: A is bit 6 down to G at bit 0
   function automatic logic [6:0] letters(input string s);
      logic [6:0] v = '0;
      for (int i = 0; i < s.len(); i++) v[6 - (s[i] - "A")] = 1'b1;
      return v;
   endfunction

   function automatic string shape(input logic [3:0] n, input logic hx);
      case (n)
         4'd0: return "ABCDEF";
         4'd1: return "BC";
         4'd2: return "ABDEG";
         4'd3: return "ABCDG";
         4'd4: return "BCFG";
         4'd5: return "ACDFG";
         4'd6: return "ACDEFG";
         4'd7: return "ABC";
         4'd8: return "ABCDEFG";
         4'd9: return "ABCDFG";
         4'hA: return hx ? "ABCEFG" : "G";
         4'hB: return hx ? "CDEFG"  : "ADEFG";
         4'hC: return hx ? "ADEF"   : "BCEFG";
         4'hD: return hx ? "BCDEG"  : "DEF";
         4'hE: return hx ? "ADEFG"  : "ABEFG";
         default: return hx ? "AEFG" : "";
      endcase
   endfunction

   function automatic logic [7:0] model(input logic [7:0] b, input logic [2:0] ix,
                                        input logic [7:0] m, input logic hx);
      if (!m[ix]) return b;
      return {b[7], letters(shape(b[3:0], hx))};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: seg_o=%h expected %h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, compare at the next falling edge
   task automatic apply(input string req, input logic [7:0] b, input logic [2:0] ix,
                        input logic [7:0] m, input logic hx);
      @(negedge clk);
      digit_byte = b; digit_idx = ix; decode_mask = m; hex_font = hx;
      @(negedge clk);
      check(req, seg_o, model(b, ix, m, hx));
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not end, actual running expected done");
         finish_run();
      end
   end

   initial begin
      process::self().srandom(32'd1106);
      repeat (3) @(negedge clk);
      // R1: reset value
      check("R1", seg_o, 8'h00);
      digit_byte = 8'hFF; decode_mask = 8'hFF;
      @(negedge clk);
      rst_n = 1'b1;
      #1 check("R1", seg_o, 8'h00);

      // R3: walking one through the bypass path
      for (int k = 0; k < 8; k++) apply("R3", 8'(1 << k), 3'd2, 8'h00, 1'b0);

      // R6 R7: numeric font, every nibble
      for (int n = 0; n < 16; n++) apply(n < 10 ? "R6" : "R7", 8'(n), 3'd5, 8'h20, 1'b0);
      // R8: hex font, every nibble
      for (int n = 0; n < 16; n++) apply("R8", 8'(n), 3'd5, 8'h20, 1'b1);

      // R4: upper bits ignored in decode mode
      apply("R4", 8'h73, 3'd0, 8'h01, 1'b0);
      check("R4", seg_o, {1'b0, letters("ABCDG")});
      apply("R4", 8'h4C, 3'd0, 8'h01, 1'b1);
      check("R4", seg_o, {1'b0, letters("ADEF")});

      // R5: decimal point in both modes
      apply("R5", 8'h8F, 3'd3, 8'h08, 1'b0);
      check("R5", seg_o, 8'h80);
      apply("R5", 8'h85, 3'd3, 8'h00, 1'b1);

      // R2: font select has no effect in bypass
      apply("R2", 8'h5A, 3'd6, 8'hBF, 1'b1);
      apply("R2", 8'h5A, 3'd6, 8'hBF, 1'b0);
      check("R2", seg_o, 8'h5A);

      // R2 R6: one mask bit, sweep every digit index
      for (int d = 0; d < 8; d++) apply("R2", 8'h02, 3'(d), 8'h10, 1'b0);

      // R9: the output holds until the next rising edge
      apply("R9", 8'h01, 3'd1, 8'h02, 1'b0);
      @(negedge clk);
      digit_idx = 3'd2;
      #1 check("R9", seg_o, {1'b0, letters("BC")});
      @(negedge clk);
      check("R9", seg_o, 8'h01);

      // Random mix
      for (int r = 0; r < 1500; r++)
         apply("R2 R4 R5 R6 R7 R8", 8'($urandom), 3'($urandom), 8'($urandom), 1'($urandom));

      done = 1;
      finish_run();
   end
endmodule